// File: doc/BRIEF.md
# Four-Line Transmit Scanner Controller

This block is the transmit half of a serial multiplexer that drives four asynchronous lines through one shared data register. Software enables lines in a line-enable register and turns on scanning in the control/status register. A round-robin scanner looks for an enabled line whose transmitter can take a byte. When it finds one, it raises a ready flag and reports the line number next to that flag. Software reads the status, then writes the byte to the transmit data register. It never addresses a line directly: the byte goes to the line being reported.

The same data write also sets four break-force bits, one for each line. A software clear resets the whole controller over a fixed number of cycles, and the clear bit reads back as set during that time. The interrupt output is the ready flag gated by a transmit interrupt enable. The bit serializers lie outside the block. Each one is seen only through a ready input and a one-cycle load strobe.

Register map: address 0 is the control/status register, address 1 is the line-enable register (bits 3:0), and address 2 is the transmit data register.

Top module: `mtx_scan_ctrl`

## Requirements
- R1: After reset, all three registers read 0. The ready flag, `irq`, every `load_valid` bit and every `brk_force` bit are 0.
- R2: When scanning is on (status bit 5 = 1), the scanner looks for a line n whose enable bit n and `line_ready[n]` are both 1. Two clocks after that condition holds, status bit 15 reads 1 and status bits 9:8 hold n.
- R3: A write to address 2 while bit 15 is set pulses `load_valid` for one cycle, in the same cycle as the write. Only the bit of the reported line is set, and `load_data` carries write bits 7:0. A write to address 2 while bit 15 is clear loads no line.
- R4: The search is round-robin. It starts at the line after the last line served and wraps from 3 to 0. The first search after reset starts at line 0.
- R5: Bit 15 drops on the clock edge that takes the data write. It can be set again, possibly for another line, one cycle later.
- R6: Bits 11:8 of every accepted write to address 2 drive `brk_force[3:0]`. They hold until the next such write, and a read of address 2 returns them at bits 11:8.
- R7: A status write with bit 4 = 1 starts a clear. Bit 4 reads 1 for CLR_CYCLES cycles and then 0. Every register returns to its reset value, and all writes made during the clear are ignored.
- R8: Scanning runs only while status bit 5 is 1. Clearing that bit withdraws an offered line within two cycles.
- R9: Clearing the enable bit of the offered line withdraws the offer within two cycles, even if the line is still ready. A new search then follows.
- R10: `irq` is 1 exactly when bit 15 and the transmit interrupt enable (status bit 14) are both 1. The receive interrupt enable (bit 6) is stored and read back, but it has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| line_ready | input | 4 | Per-line transmitter can accept a byte |
| load_valid | output | 4 | One-cycle byte load strobe per line |
| load_data | output | 8 | Byte being loaded |
| brk_force | output | 4 | Per-line break force |
| irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume that a transmitter keeps `line_ready` high until it receives a load, and that software writes the data register only after it has seen the ready flag. A write that ignores the flag is legal, but it loads nothing. The bench drives `line_ready` low in the same cycle as each load, so every search after a load sees settled ready inputs. It holds `line_ready` steady while it changes enables or the scan bit, so that each withdrawal has one clear cause.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int NUM_LINES = 4;
  localparam int LINE_W    = $clog2(NUM_LINES);

  typedef logic [NUM_LINES-1:0] line_mask_t;
  typedef logic [LINE_W-1:0]    line_idx_t;

  localparam logic [1:0] A_CSR = 2'd0;
  localparam logic [1:0] A_TCR = 2'd1;
  localparam logic [1:0] A_TDR = 2'd2;

  localparam int CSR_CLR   = 4;
  localparam int CSR_SCAN  = 5;
  localparam int CSR_RIE   = 6;
  localparam int CSR_LINE  = 8;
  localparam int CSR_TIE   = 14;
  localparam int CSR_TRDY  = 15;
  localparam int BRK_LO    = 8;

  // Round-robin pick: first requesting line after 'last', wrapping.
  // Result is {found, index}.
  function automatic logic [LINE_W:0] rr_pick(line_mask_t req, line_idx_t last);
    logic      found;
    line_idx_t idx;
    line_idx_t cand;
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= NUM_LINES; k++) begin
      cand = last + line_idx_t'(k);
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
    return {found, idx};
  endfunction
endpackage

// File: rtl/mtx_regs.sv
module mtx_regs
  import mtx_pkg::*;
#(
  parameter int CLR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic        scan_en,
  output logic        rx_ie,
  output logic        tx_ie,
  output line_mask_t  line_en,
  output line_mask_t  brk,
  output logic        clearing,
  output logic        clr_start,
  output logic        tdr_wr
);
  localparam int CW = $clog2(CLR_CYCLES + 1);

  logic [CW-1:0] clr_cnt;
  logic          wr_ok;

  assign clearing  = (clr_cnt != '0);
  assign wr_ok     = wr_en && !clearing;
  assign clr_start = wr_ok && (wr_addr == A_CSR) && wr_data[CSR_CLR];
  assign tdr_wr    = wr_ok && (wr_addr == A_TDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_cnt <= '0;
      scan_en <= 1'b0;
      rx_ie   <= 1'b0;
      tx_ie   <= 1'b0;
      line_en <= '0;
      brk     <= '0;
    end else if (clr_start) begin
      clr_cnt <= CW'(CLR_CYCLES);
      scan_en <= 1'b0;
      rx_ie   <= 1'b0;
      tx_ie   <= 1'b0;
      line_en <= '0;
      brk     <= '0;
    end else if (clearing) begin
      clr_cnt <= clr_cnt - 1'b1;
    end else if (wr_ok) begin
      case (wr_addr)
        A_CSR: begin
          scan_en <= wr_data[CSR_SCAN];
          rx_ie   <= wr_data[CSR_RIE];
          tx_ie   <= wr_data[CSR_TIE];
        end
        A_TCR:   line_en <= wr_data[NUM_LINES-1:0];
        A_TDR:   brk     <= wr_data[BRK_LO +: NUM_LINES];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mtx_scanner.sv
module mtx_scanner
  import mtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       scan_en,
  input  line_mask_t line_en,
  input  line_mask_t line_ready,
  input  logic       tdr_wr,
  output logic       tx_ready,
  output line_idx_t  cur_line,
  output logic       take
);
  line_idx_t         last_line;
  logic [LINE_W:0]   pick;
  logic              offer_lost;

  assign pick       = rr_pick(line_en & line_ready, last_line);
  assign take       = tdr_wr && tx_ready;
  assign offer_lost = tx_ready && (!scan_en || !line_en[cur_line]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ready  <= 1'b0;
      cur_line  <= '0;
      last_line <= line_idx_t'(NUM_LINES - 1);
    end else if (flush) begin
      tx_ready  <= 1'b0;
      cur_line  <= '0;
      last_line <= line_idx_t'(NUM_LINES - 1);
    end else if (take) begin
      tx_ready  <= 1'b0;
      last_line <= cur_line;
    end else if (offer_lost) begin
      tx_ready  <= 1'b0;
    end else if (!tx_ready && scan_en && pick[LINE_W]) begin
      tx_ready  <= 1'b1;
      cur_line  <= pick[LINE_W-1:0];
    end
  end
endmodule

// File: rtl/mtx_scan_ctrl.sv
module mtx_scan_ctrl
  import mtx_pkg::*;
#(
  parameter int CLR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic [3:0]  line_ready,
  output logic [3:0]  load_valid,
  output logic [7:0]  load_data,
  output logic [3:0]  brk_force,
  output logic        irq
);
  logic       scan_en, rx_ie, tx_ie, clearing, clr_start, tdr_wr;
  line_mask_t line_en, brk;
  logic       tx_ready, take;
  line_idx_t  cur_line;

  mtx_regs #(.CLR_CYCLES(CLR_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .scan_en(scan_en), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .line_en(line_en), .brk(brk), .clearing(clearing),
    .clr_start(clr_start), .tdr_wr(tdr_wr)
  );

  mtx_scanner u_scan (
    .clk(clk), .rst_n(rst_n), .flush(clr_start | clearing),
    .scan_en(scan_en), .line_en(line_en), .line_ready(line_ready),
    .tdr_wr(tdr_wr), .tx_ready(tx_ready), .cur_line(cur_line), .take(take)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_load
    assign load_valid[i] = take && (cur_line == line_idx_t'(i));
  end

  assign load_data = wr_data[7:0];
  assign brk_force = brk;
  assign irq       = tx_ready && tx_ie;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CSR: begin
        rd_data[CSR_CLR]             = clearing;
        rd_data[CSR_SCAN]            = scan_en;
        rd_data[CSR_RIE]             = rx_ie;
        rd_data[CSR_LINE +: LINE_W]  = cur_line;
        rd_data[CSR_TIE]             = tx_ie;
        rd_data[CSR_TRDY]            = tx_ready;
      end
      A_TCR:   rd_data[NUM_LINES-1:0]       = line_en;
      A_TDR:   rd_data[BRK_LO +: NUM_LINES] = brk;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mtx_scan_ctrl_chk.sv
module mtx_scan_ctrl_chk
  import mtx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_ready,
  input line_idx_t  cur_line,
  input line_mask_t line_en,
  input logic [3:0] line_ready,
  input logic       scan_en,
  input logic       clearing,
  input logic       clr_start,
  input logic [3:0] load_valid,
  input logic       irq
);
  // R2: an offer only appears for a line that was enabled and ready while scanning
  p_offer_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(scan_en) &&
      (|(($past(line_en) & $past(line_ready)) & (line_mask_t'(1) << cur_line))));

  p_load_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_valid));

  p_load_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_valid) |-> tx_ready && load_valid[cur_line]);

  p_drop_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_valid) |=> !tx_ready);

  p_offer_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !(|load_valid) && scan_en && line_en[cur_line] &&
     !clearing && !clr_start) |=> tx_ready && $stable(cur_line));

  p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !line_en[cur_line]) |=> !tx_ready);

  p_withdraw_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !scan_en) |=> !tx_ready);

  p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !tx_ready && (line_en == '0) && !scan_en);

  p_irq_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tx_ready);
endmodule

bind mtx_scan_ctrl mtx_scan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .cur_line(cur_line),
  .line_en(line_en), .line_ready(line_ready), .scan_en(scan_en),
  .clearing(clearing), .clr_start(clr_start), .load_valid(load_valid),
  .irq(irq)
);

// File: tb/mtx_scan_ctrl_test.sv
module mtx_scan_ctrl_test;
  localparam int CLR = 4;
  localparam logic [15:0] SCAN = 16'h0020;
  localparam logic [15:0] TIE  = 16'h4000;
  localparam logic [15:0] RIE  = 16'h0040;
  localparam logic [15:0] CLRB = 16'h0010;

  // {enable[3:0], ready[3:0], expected line[3:0], data byte[7:0]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    20'hFF041, 20'hFF142, 20'hFF243, 20'hFF344,
    20'h5F045, 20'h5F246, 20'hF9347, 20'hF9048,
    20'h2F149, 20'h2F14A, 20'hC424B, 20'h8834C
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  line_ready = '0;
  logic [3:0]  load_valid;
  logic [7:0]  load_data;
  logic [3:0]  brk_force;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mtx_scan_ctrl #(.CLR_CYCLES(CLR)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .line_ready(line_ready), .load_valid(load_valid),
    .load_data(load_data), .brk_force(brk_force), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 csr", v, 0);
    rd(2'd1, v); check("R1 tcr", v, 0);
    rd(2'd2, v); check("R1 tdr", v, 0);
    check("R1 irq/load/brk", {irq, load_valid, brk_force}, 0);
    @(negedge clk) rst_n = 1'b1;

    wr(2'd0, SCAN | TIE);

    // Table: round-robin service under enable/ready patterns
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, {12'd0, VEC[i][19:16]});
      line_ready = VEC[i][15:12];
      repeat (3) @(negedge clk);
      rd(2'd0, v);
      check($sformatf("R2 ready vec%0d", i), v[15], 1);
      check($sformatf("R4 line vec%0d", i), v[9:8], VEC[i][9:8]);
      check($sformatf("R10 irq vec%0d", i), irq, 1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = {8'd0, VEC[i][7:0]};
      line_ready = 4'd0;
      #1;
      check($sformatf("R3 strobe vec%0d", i), load_valid, 4'b1 << VEC[i][9:8]);
      check($sformatf("R3 data vec%0d", i), load_data, VEC[i][7:0]);
      @(negedge clk);
      wr_en = 1'b0;
      rd(2'd0, v);
      check($sformatf("R5 drop vec%0d", i), v[15], 0);
    end

    // R5: re-evaluation one cycle after a load moves to the next line
    wr(2'd1, 16'h0003);
    line_ready = 4'h3;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R4 wrap to line0", {v[15], v[9:8]}, {1'b1, 2'd0});
    wr(2'd2, 16'h0011);
    rd(2'd0, v); check("R5 drop on write", v[15], 0);
    @(negedge clk);
    rd(2'd0, v); check("R5 re-offer next line", {v[15], v[9:8]}, {1'b1, 2'd1});
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0022; line_ready = 4'd0;
    #1; check("R3 second load", load_valid, 4'b0010);
    @(negedge clk); wr_en = 1'b0;

    // R8: scan enable gates scanning and withdraws an offer
    wr(2'd0, TIE);
    line_ready = 4'hF;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R8 no scan", v[15], 0);
    wr(2'd0, SCAN | TIE);
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R8 scan on line0", {v[15], v[9:8]}, {1'b1, 2'd0});
    wr(2'd0, TIE);
    @(negedge clk);
    rd(2'd0, v); check("R8 withdrawn", v[15], 0);

    // R9: disabling the offered line withdraws it, then rescans
    wr(2'd0, SCAN | TIE);
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R9 offered line0", {v[15], v[9:8]}, {1'b1, 2'd0});
    wr(2'd1, 16'h0002);
    @(negedge clk);
    rd(2'd0, v); check("R9 withdrawn", v[15], 0);
    @(negedge clk);
    rd(2'd0, v); check("R9 rescan line1", {v[15], v[9:8]}, {1'b1, 2'd1});

    // R10: receive enable has no effect on irq
    wr(2'd0, SCAN | RIE);
    rd(2'd0, v);
    check("R10 rie readback", {v[15], v[6], v[14]}, 3'b110);
    check("R10 irq off", irq, 0);

    // R6: break bits, and R3 write without ready loads nothing
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0577; line_ready = 4'd0;
    #1; check("R3 load line1", load_valid, 4'b0010);
    @(negedge clk); wr_en = 1'b0;
    check("R6 break set", brk_force, 4'h5);
    repeat (2) @(negedge clk);
    check("R6 break held", brk_force, 4'h5);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0A99;
    #1; check("R3 no load without ready", load_valid, 4'd0);
    @(negedge clk); wr_en = 1'b0;
    check("R6 break update", brk_force, 4'hA);
    rd(2'd2, v); check("R6 tdr read", v, 16'h0A00);

    // R7: software clear
    wr(2'd0, CLRB | SCAN | TIE);
    rd(2'd0, v); check("R7 clear busy", v[4], 1);
    check("R7 break cleared", brk_force, 0);
    wr(2'd1, 16'h000F);
    rd(2'd0, v); check("R7 still busy", v[4], 1);
    @(negedge clk);
    rd(2'd0, v); check("R7 last busy cycle", v[4], 1);
    @(negedge clk);
    rd(2'd0, v); check("R7 clear done", v, 0);
    rd(2'd1, v); check("R7 write ignored", v, 0);
    rd(2'd2, v); check("R7 tdr zero", v, 0);

    finish_run();
  end
endmodule